// File: doc/BRIEF.md
# Computer-Operating-Properly Watchdog

This block guards a processor against runaway code. A free-running timeout chain counts input clock cycles. The low part of the chain acts as a prescaler, and the high part acts as an overflow counter. Software must write to one fixed service address before the chain reaches its selected tap. If it does not, the block drives an active-low reset pulse of fixed length. It also sets a sticky flag so that boot code can tell that the last reset came from the watchdog.

A write to the service address clears the chain from bit 4 upward. The lowest four bits keep counting, so the guaranteed window after a service is 2^N − 2^4 cycles. A configuration input selects between a long tap (N = 18 by default) and a short tap (N = 13 by default). Both taps follow the same clear rule. A disable input represents the monitor or high-voltage condition. While it is high, the chain is held cleared and no reset can be issued.

Top module: `cop_watchdog`

## Requirements
- R1: With the long setting (long_sel = 1), no service write and the chain starting from zero, wd_rst_n first reads low after edge 2^N_LONG, where N_LONG = PRE_W + OVF_W (18 by default).
- R2: With the short setting (long_sel = 0), the overflow is taken from bit N_SHORT − 1 with N_SHORT = PRE_W + OVF_W − SHORT_DROP (13 by default), and wd_rst_n first reads low after edge 2^N_SHORT.
- R3: A service is a cycle with bus_wr = 1 and bus_addr = 16'hFFFF, with any bus_data value. The service clears chain bits KEEP_LOW (4) and up, while bits 3..0 keep incrementing. When the service occupies edge i, the next expiry is at edge i + 2^N − (i mod 16).
- R4: A write to any address other than 16'hFFFF leaves the chain and the expiry time unchanged.
- R5: A service on the same edge as the overflow wins: no reset pulse follows, and the next expiry is at edge 2^(N+1) from the start.
- R6: An expiry drives wd_rst_n low for exactly PULSE_CYCLES (32) consecutive clock cycles. The pulse is not retriggered while it is active.
- R7: The chain is held at zero during the pulse. After a pulse that starts at edge E, the next expiry with no service is at edge E + 32 + 2^N.
- R8: wd_flag goes to 1 on the edge that starts a pulse. It stays at 1 through later service writes and later pulses, until rst_n is asserted.
- R9: While wd_disable = 1, wd_rst_n stays high and the chain is held at zero. If wd_disable is last high on edge j, the next expiry is at edge j + 2^N.
- R10: While rst_n = 0 (synchronous, active low), wd_rst_n = 1, wd_flag = 0 and the chain is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that the timeout chain counts |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe of the bus port |
| bus_addr | input | ADDR_W | Write address |
| bus_data | input | DATA_W | Write data (value ignored) |
| long_sel | input | 1 | 1 selects the long timeout, 0 the short one |
| wd_disable | input | 1 | Monitor or high-voltage condition; suppresses the watchdog |
| wd_rst_n | output | 1 | Active-low reset pulse |
| wd_flag | output | 1 | Sticky flag: last reset came from the watchdog |

## Verification
The chain register sits before the pulse register, so a chain value of 2^N − 1 shows up as a low wd_rst_n one edge later. The first low sample therefore falls exactly after edge 2^N, counted from the first edge with rst_n high. A service driven before edge i changes the chain on edge i, so the bench computes expected expiry edges with the rule i + 2^N − (i mod 16). wd_flag updates on the same edge as the falling reset, and the pulse stays low for 32 samples. The bench drives inputs 1 ns after each rising edge and samples there. Each check therefore compares the edge count at which a value was sampled against an expected edge count. The bench uses a reduced chain (N_LONG = 12, N_SHORT = 7) so that every expiry stays short enough to observe.

// File: rtl/cop_wd_pkg.sv
// Package: shared types for the watchdog.
// Assumes: nothing beyond standard SystemVerilog.
package cop_wd_pkg;

    // Timeout tap selection encoding (matches the long_sel pin).
    typedef enum logic {
        TMO_SHORT = 1'b0,
        TMO_LONG  = 1'b1
    } tmo_sel_e;

endpackage

// File: rtl/cop_wd_decode.sv
// Module: service-write decoder.
// Flags a write strobe aimed at the service address; data value is ignored.
// Assumes: the bus presents address and strobe in the same cycle.
module cop_wd_decode #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] SVC_ADDR = '1
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    output logic              svc_hit
);

    logic data_unused;

    // Purpose: any data value services; fold it so it is knowingly unused.
    assign data_unused = ^bus_data;

    // Purpose: a hit is a strobe to the one fixed service address.
    assign svc_hit = bus_wr && (bus_addr == SVC_ADDR);

endmodule

// File: rtl/cop_wd_chain.sv
// Module: timeout chain (prescaler low bits + overflow counter high bits).
// Counts every clock; a service clears bits KEEP_LOW and up; hold clears all.
// Reports when the selected tap is all ones (next edge would overflow).
// Assumes: SHORT_DROP < PRE_W + OVF_W - KEEP_LOW.
module cop_wd_chain
    import cop_wd_pkg::*;
#(
    parameter int PRE_W      = 12,
    parameter int OVF_W      = 6,
    parameter int SHORT_DROP = 5,
    parameter int KEEP_LOW   = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     hold,
    input  logic     svc,
    input  tmo_sel_e sel,
    output logic     tap_full
);

    localparam int TOTAL_W = PRE_W + OVF_W;
    localparam int SHORT_W = TOTAL_W - SHORT_DROP;

    logic [TOTAL_W-1:0] cnt;
    logic [TOTAL_W-1:0] inc;
    logic [TOTAL_W-1:0] nxt;
    logic               long_full;
    logic               short_full;

    // Purpose: free-running increment of the whole chain.
    assign inc = cnt + TOTAL_W'(1);

    // Purpose: per stage, service clears the upper stages, low stages run on.
    for (genvar b = 0; b < TOTAL_W; b++) begin : g_stage
        if (b >= KEEP_LOW) begin : g_upper
            assign nxt[b] = svc ? 1'b0 : inc[b];
        end else begin : g_lower
            assign nxt[b] = inc[b];
        end
    end

    // Purpose: chain register, cleared by reset or hold.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            cnt <= '0;
        end else begin
            cnt <= nxt;
        end
    end

    // Purpose: detect the selected tap about to roll over.
    assign long_full  = &cnt;
    assign short_full = &cnt[SHORT_W-1:0];
    assign tap_full   = (sel == TMO_LONG) ? long_full : short_full;

    AST_HOLD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (cnt == '0)); // R7

    AST_SERVICE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (svc && !hold) |=> (cnt[TOTAL_W-1:KEEP_LOW] == '0)); // R3

endmodule

// File: rtl/cop_wd_pulse.sv
// Module: reset pulse generator and sticky source flag.
// An expire request starts a fixed-length low pulse and sets the flag.
// Assumes: expire is never raised while active (gated by the parent).
module cop_wd_pulse #(
    parameter int PULSE_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    output logic active,
    output logic rst_out_n,
    output logic flag
);

    localparam int PW = $clog2(PULSE_CYCLES + 1);

    logic [PW-1:0] pcnt;

    // Purpose: load the pulse length on expiry, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (expire) begin
            pcnt <= PW'(PULSE_CYCLES);
        end else if (pcnt != '0) begin
            pcnt <= pcnt - PW'(1);
        end
    end

    // Purpose: sticky flag, cleared only by the external reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (expire) begin
            flag <= 1'b1;
        end
    end

    // Purpose: pulse is low while the countdown is non-zero.
    assign active    = (pcnt != '0);
    assign rst_out_n = !active;

    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> !expire); // R6

    AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !rst_out_n); // R6

    AST_FLAG_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out_n) |-> flag); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag |=> flag); // R8

endmodule

// File: rtl/cop_watchdog.sv
// Module: computer-operating-properly watchdog top.
// Joins the service decoder, the timeout chain and the pulse generator.
// Assumes: single clock domain; rst_n synchronous active-low.
module cop_watchdog
    import cop_wd_pkg::*;
#(
    parameter int PRE_W        = 12,
    parameter int OVF_W        = 6,
    parameter int SHORT_DROP   = 5,
    parameter int KEEP_LOW     = 4,
    parameter int PULSE_CYCLES = 32,
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 8,
    parameter logic [ADDR_W-1:0] SVC_ADDR = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              long_sel,
    input  logic              wd_disable,
    output logic              wd_rst_n,
    output logic              wd_flag
);

    logic     svc_hit;
    logic     tap_full;
    logic     pulse_active;
    logic     hold;
    logic     expire;
    tmo_sel_e sel;

    // Purpose: map the pin to the tap selection type.
    assign sel = long_sel ? TMO_LONG : TMO_SHORT;

    // Purpose: chain is frozen at zero during a pulse or when disabled.
    assign hold = pulse_active || wd_disable;

    // Purpose: expiry unless a same-cycle service or hold overrides it.
    assign expire = tap_full && !svc_hit && !hold;

    cop_wd_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .SVC_ADDR (SVC_ADDR)
    ) i_decode (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_data (bus_data),
        .svc_hit  (svc_hit)
    );

    cop_wd_chain #(
        .PRE_W      (PRE_W),
        .OVF_W      (OVF_W),
        .SHORT_DROP (SHORT_DROP),
        .KEEP_LOW   (KEEP_LOW)
    ) i_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .svc      (svc_hit),
        .sel      (sel),
        .tap_full (tap_full)
    );

    cop_wd_pulse #(
        .PULSE_CYCLES (PULSE_CYCLES)
    ) i_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire    (expire),
        .active    (pulse_active),
        .rst_out_n (wd_rst_n),
        .flag      (wd_flag)
    );

    AST_SERVICE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_hit && wd_rst_n) |=> wd_rst_n); // R5

    AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_disable && wd_rst_n) |=> wd_rst_n); // R9

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (wd_rst_n && !wd_flag)); // R10

endmodule

// File: tb/test_cop_watchdog.sv
// Bench: vector table walked by one loop, then directed corner tests.
module test_cop_watchdog;

    localparam int TB_PRE   = 8;
    localparam int TB_OVF   = 4;
    localparam int TB_DROP  = 5;
    localparam int N_LONG   = TB_PRE + TB_OVF;
    localparam int N_SHORT  = N_LONG - TB_DROP;
    localparam int PULSE    = 32;
    localparam int WD_LIMIT = 150000;
    localparam int NVEC     = 10;

    // {long_sel, service edge (0 = none), address, data}
    localparam logic [40:0] VEC [NVEC] = '{
        {1'b0, 16'd0,    16'hFFFF, 8'h00},
        {1'b1, 16'd0,    16'hFFFF, 8'h00},
        {1'b0, 16'd100,  16'hFFFF, 8'h00},
        {1'b0, 16'd37,   16'hFFFF, 8'hA5},
        {1'b0, 16'd127,  16'hFFFF, 8'hFF},
        {1'b0, 16'd128,  16'hFFFF, 8'h3C},
        {1'b0, 16'd100,  16'hFFFE, 8'h00},
        {1'b1, 16'd4000, 16'hFFFF, 8'h5A},
        {1'b0, 16'd64,   16'h7FFF, 8'h11},
        {1'b1, 16'd4096, 16'hFFFF, 8'h81}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic        long_sel = 1'b0;
    logic        wd_disable = 1'b0;
    logic        wd_rst_n;
    logic        wd_flag;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    cop_watchdog #(
        .PRE_W        (TB_PRE),
        .OVF_W        (TB_OVF),
        .SHORT_DROP   (TB_DROP),
        .KEEP_LOW     (4),
        .PULSE_CYCLES (PULSE),
        .ADDR_W       (16),
        .DATA_W       (8),
        .SVC_ADDR     (16'hFFFF)
    ) i_cop_watchdog (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_data   (bus_data),
        .long_sel   (long_sel),
        .wd_disable (wd_disable),
        .wd_rst_n   (wd_rst_n),
        .wd_flag    (wd_flag)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WD_LIMIT) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, WD_LIMIT);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_first(input logic lsel, input int svc, input logic [15:0] addr);
        int n = lsel ? N_LONG : N_SHORT;
        if (svc == 0 || addr != 16'hFFFF) return (1 << n);
        return svc + (1 << n) - (svc % 16);
    endfunction

    task automatic enter_reset();
        rst_n = 1'b0;
        bus_wr = 1'b0;
        wd_disable = 1'b0;
        repeat (3) tick();
    endtask

    // Count edges until wd_rst_n reads low; bounded.
    task automatic wait_low(input int limit, output int at);
        at = -1;
        for (int e = 1; e <= limit && at < 0; e++) begin
            tick();
            if (!wd_rst_n) at = e;
        end
    endtask

    // Count consecutive low samples, the first already seen.
    task automatic measure_low(output int width);
        width = 1;
        while (width < 200) begin
            tick();
            if (wd_rst_n) break;
            width++;
        end
    endtask

    initial begin
        int first;
        int width;
        int base;

        // R10: reset state
        enter_reset();
        check(wd_rst_n == 1'b1, "R10 reset wd_rst_n", wd_rst_n, 1);
        check(wd_flag == 1'b0, "R10 reset wd_flag", wd_flag, 0);

        // Table walk: R1 R2 R3 R4 R5 with R6 and R8 on each pulse
        for (int v = 0; v < NVEC; v++) begin
            logic        lsel = VEC[v][40];
            int          svc  = int'(VEC[v][39:24]);
            logic [15:0] adr  = VEC[v][23:8];
            logic [7:0]  dat  = VEC[v][7:0];
            int          expd = exp_first(lsel, svc, adr);
            enter_reset();
            long_sel = lsel;
            rst_n = 1'b1;
            first = -1;
            for (int e = 1; e <= 3 * (1 << N_LONG) && first < 0; e++) begin
                bus_wr   = (e == svc);
                bus_addr = adr;
                bus_data = dat;
                tick();
                if (!wd_rst_n) first = e;
            end
            bus_wr = 1'b0;
            check(first == expd, "R1/R2/R3/R4/R5 first expiry edge", first, expd);
            check(wd_flag == 1'b1, "R8 flag set with pulse", wd_flag, 1);
            measure_low(width);
            check(width == PULSE, "R6 pulse width", width, PULSE);
        end

        // R7: restart from zero after pulse; R8: service does not clear flag
        enter_reset();
        long_sel = 1'b0;
        rst_n = 1'b1;
        wait_low(1000, first);
        check(first == (1 << N_SHORT), "R2 short expiry", first, 1 << N_SHORT);
        base = first;
        measure_low(width);
        bus_wr = 1'b1; bus_addr = 16'hFFFF; bus_data = 8'h00;
        tick();
        bus_wr = 1'b0;
        check(wd_flag == 1'b1, "R8 flag kept after service", wd_flag, 1);
        // pulse started at edge base; measure_low ended at edge base+32, one service edge after
        enter_reset();
        long_sel = 1'b0;
        rst_n = 1'b1;
        wait_low(1000, first);
        measure_low(width);
        wait_low(1000, first);
        // first counted from edge base+32, so next pulse lies 2^N later
        check(first == (1 << N_SHORT), "R7 restart after pulse", first, 1 << N_SHORT);
        check(wd_flag == 1'b1, "R8 flag kept across pulses", wd_flag, 1);

        // R10: external reset clears the flag
        rst_n = 1'b0;
        tick();
        check(wd_flag == 1'b0, "R10 reset clears flag", wd_flag, 0);
        check(wd_rst_n == 1'b1, "R10 reset releases output", wd_rst_n, 1);

        // R9: disable suppresses reset, then counting restarts from zero
        enter_reset();
        long_sel = 1'b0;
        wd_disable = 1'b1;
        rst_n = 1'b1;
        wait_low(400, first);
        check(first == -1, "R9 no pulse while disabled", first, -1);
        wd_disable = 1'b0;
        wait_low(1000, first);
        check(first == (1 << N_SHORT), "R9 expiry after disable drops", first, 1 << N_SHORT);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule